// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration image into an SRAM-based programmable device over a passive serial link. A host pulses `start_i` and presents a byte count. The block then runs the device reset handshake. It pulls the active-low configuration request low for a hold time, confirms that the device answers by asserting its active-low status line, and releases the request. It then waits for the status line to be released, giving up after a bounded timeout.

Image bytes arrive on a valid/ready stream. Each byte is shifted out least-significant bit first. A bit is placed on the data line while the configuration clock is low, and the device samples it on the clock's rising edge. After the last byte the block requires the device's done line to be high. It then issues a fixed number of trailing clock pulses to finish device start-up and reports success. Any failure ends the load and leaves a 2-bit code on `err_o` until the next start.

All delays are derived from the system clock frequency parameter. The configuration clock half-period is set in system cycles, and must be chosen so that the link clock stays at or below the device's 50 MHz limit.

Top module: `pscfg_master`

## Requirements
- R1: Out of reset and while not busy, `nconfig_o` is high, `ready_o` is low, `busy_o` is low, and `dclk_o` and `data_o` are low. `busy_o` is high from the cycle after `start_i` is taken until the load ends.
- R2: After a start, `nconfig_o` is driven low for exactly `ceil(HOLD_NS * CLK_HZ / 1e9)` system cycles (at least 2 µs at the default values).
- R3: If `nstatus_i` is high (not asserted) in the last cycle of that hold, the load ends with `err_o` = 1 and no configuration clock edge is produced.
- R4: After the request is released, the block waits one further hold time and then polls `nstatus_i`. If it is still low after `TIMEOUT_NS` worth of cycles, the load ends with `err_o` = 2.
- R5: Each byte is sent as 8 bits, bit 0 first. A bit is set on `data_o` when `dclk_o` goes low and stays stable through the following rising edge.
- R6: Every low and every high phase of `dclk_o` lasts at least `DCLK_HALF_CYC` system cycles.
- R7: If `conf_done_i` is low once the last byte has been shifted, the load ends with `err_o` = 3 and no trailing pulses are produced.
- R8: After a good done check, exactly `TRAIL_PULSES` (default 12) further rising edges are produced on `dclk_o`. The clock ends low, and then `done_o` rises with `err_o` = 0.
- R9: `abort_i` high while the block waits for the next byte ends the load with `err_o` = 3, and no further clock edges are produced.
- R10: `ready_o` is high only while a byte is still owed and the shifter is empty. It drops in the cycle after a handshake, so the number of accepted bytes equals `byte_count_i`.
- R11: `err_o` and `done_o` hold their values while idle. A new start clears both in the following cycle.
- R12: A byte count of zero skips streaming. The block goes straight to the done check and then to the trailing pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (taken while idle) |
| byte_count_i | input | CNT_W | Number of image bytes, sampled at start |
| data_i | input | 8 | Image byte |
| valid_i | input | 1 | Image byte present |
| ready_o | output | 1 | Block accepts an image byte |
| abort_i | input | 1 | Host abort, honoured between bytes |
| nconfig_o | output | 1 | Active-low configuration request to device |
| dclk_o | output | 1 | Configuration clock to device |
| data_o | output | 1 | Serial configuration data to device |
| nstatus_i | input | 1 | Active-low status from device |
| conf_done_i | input | 1 | Configuration done from device |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load succeeded |
| err_o | output | 2 | 0 none, 1 status not asserted, 2 status timeout, 3 done missing or aborted |

## Verification
The assertions assume that `nstatus_i`, `conf_done_i`, `abort_i`, `valid_i` and `data_i` are synchronous to `clk` and settled before each rising edge. They also assume that `data_i` holds steady while `valid_i` waits for `ready_o`. The stimulus meets this by changing every input half a cycle away from the active edge. The device model drives the status line from the observed request line with a fixed release delay, and the host asserts abort only while no byte is offered.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULL,
        ST_RELEASE,
        ST_POLL,
        ST_FETCH,
        ST_SHIFT,
        ST_CHECK,
        ST_TRAIL
    } pscfg_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_NOSTAT  = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_BOOT    = 2'd3
    } pscfg_err_e;

    // Command from the sequencer to the bit shifter
    typedef struct packed {
        logic       clr;
        logic       load_byte;
        logic       load_trail;
        logic [7:0] byte_val;
    } ser_cmd_t;

    // Whole system cycles covering a span in nanoseconds, rounded up, minimum 1
    function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                                 input longint unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = hz * ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/pscfg_delay.sv
module pscfg_delay #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] init,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= init;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pscfg_serializer.sv
module pscfg_serializer
    import pscfg_pkg::*;
#(
    parameter int unsigned HALF_CYC     = 2,
    parameter int unsigned TRAIL_PULSES = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  ser_cmd_t cmd,
    output logic     dclk_o,
    output logic     dout_o,
    output logic     idle_o
);
    localparam int unsigned HCW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int unsigned HW  = $clog2(2 * TRAIL_PULSES + 16);

    logic           busy_q;
    logic           dclk_q;
    logic           dout_q;
    logic           is_byte_q;
    logic [6:0]     shreg_q;
    logic [HW-1:0]  halves_q;
    logic [HCW-1:0] hcnt_q;

    always_ff @(posedge clk) begin
        if (rst || cmd.clr) begin
            busy_q    <= 1'b0;
            dclk_q    <= 1'b0;
            dout_q    <= 1'b0;
            is_byte_q <= 1'b0;
            shreg_q   <= '0;
            halves_q  <= '0;
            hcnt_q    <= '0;
        end else if (cmd.load_byte) begin
            // low half of bit 0 starts now, 15 more halves follow
            busy_q    <= 1'b1;
            dclk_q    <= 1'b0;
            dout_q    <= cmd.byte_val[0];
            shreg_q   <= cmd.byte_val[7:1];
            halves_q  <= HW'(15);
            hcnt_q    <= HCW'(HALF_CYC - 1);
            is_byte_q <= 1'b1;
        end else if (cmd.load_trail) begin
            // start low so that every trailing pulse has its own rising edge
            busy_q    <= 1'b1;
            dclk_q    <= 1'b0;
            dout_q    <= 1'b0;
            halves_q  <= HW'(2 * TRAIL_PULSES);
            hcnt_q    <= HCW'(HALF_CYC - 1);
            is_byte_q <= 1'b0;
        end else if (busy_q) begin
            if (hcnt_q != '0) begin
                hcnt_q <= hcnt_q - 1'b1;
            end else if (halves_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                dclk_q   <= ~dclk_q;
                halves_q <= halves_q - 1'b1;
                hcnt_q   <= HCW'(HALF_CYC - 1);
                if (dclk_q && is_byte_q) begin
                    dout_q  <= shreg_q[0];
                    shreg_q <= {1'b0, shreg_q[6:1]};
                end
            end
        end
    end

    assign dclk_o = dclk_q;
    assign dout_o = dout_q;
    assign idle_o = ~busy_q;

    // R5: data does not move on the rising clock edge
    a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk_q) |-> $stable(dout_q));

    // R6: a phase cannot end before its half-period count has run out
    a_r6_phase_len: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_q) && ($past(hcnt_q) != '0) &&
         !$past(cmd.load_byte || cmd.load_trail || cmd.clr)) |-> $stable(dclk_q));

endmodule

// File: rtl/pscfg_master.sv
module pscfg_master
    import pscfg_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 100_000_000,
    parameter int unsigned DCLK_HALF_CYC = 2,
    parameter int unsigned HOLD_NS       = 2_000,
    parameter int unsigned TIMEOUT_NS    = 100_000_000,
    parameter int unsigned TRAIL_PULSES  = 12,
    parameter int unsigned CNT_W         = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic [7:0]       data_i,
    input  logic             valid_i,
    output logic             ready_o,
    input  logic             abort_i,
    output logic             nconfig_o,
    output logic             dclk_o,
    output logic             data_o,
    input  logic             nstatus_i,
    input  logic             conf_done_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       err_o
);
    localparam int unsigned HOLD_CYC = ns_to_cycles(CLK_HZ, HOLD_NS);
    localparam int unsigned TMO_CYC  = ns_to_cycles(CLK_HZ, TIMEOUT_NS);
    localparam int unsigned MAX_CYC  = (TMO_CYC > HOLD_CYC) ? TMO_CYC : HOLD_CYC;
    localparam int unsigned TW       = $clog2(MAX_CYC + 1);

    pscfg_state_e     state_q, state_d;
    pscfg_err_e       err_q;
    logic             done_q;
    logic [CNT_W-1:0] left_q;

    logic             tmr_ld;
    logic [TW-1:0]    tmr_init;
    logic             tmr_exp;
    ser_cmd_t         cmd;
    logic             ser_idle;

    pscfg_delay #(.W(TW)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_ld),
        .init    (tmr_init),
        .expired (tmr_exp)
    );

    pscfg_serializer #(
        .HALF_CYC     (DCLK_HALF_CYC),
        .TRAIL_PULSES (TRAIL_PULSES)
    ) u_ser (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .dclk_o (dclk_o),
        .dout_o (data_o),
        .idle_o (ser_idle)
    );

    always_comb begin
        state_d      = state_q;
        tmr_ld       = 1'b0;
        tmr_init     = '0;
        cmd          = '0;
        cmd.clr      = (state_q == ST_IDLE);
        cmd.byte_val = data_i;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_PULL;
                    tmr_ld   = 1'b1;
                    tmr_init = TW'(HOLD_CYC - 1);
                end
            end
            ST_PULL: begin
                if (tmr_exp) begin
                    if (!nstatus_i) begin
                        state_d  = ST_RELEASE;
                        tmr_ld   = 1'b1;
                        tmr_init = TW'(HOLD_CYC - 1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_RELEASE: begin
                if (tmr_exp) begin
                    state_d  = ST_POLL;
                    tmr_ld   = 1'b1;
                    tmr_init = TW'(TMO_CYC - 1);
                end
            end
            ST_POLL: begin
                if (nstatus_i) begin
                    state_d = (left_q == '0) ? ST_CHECK : ST_FETCH;
                end else if (tmr_exp) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FETCH: begin
                if (abort_i) begin
                    state_d = ST_IDLE;
                end else if (valid_i) begin
                    cmd.load_byte = 1'b1;
                    state_d       = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (ser_idle) begin
                    state_d = (left_q == '0) ? ST_CHECK : ST_FETCH;
                end
            end
            ST_CHECK: begin
                if (conf_done_i) begin
                    cmd.load_trail = 1'b1;
                    state_d        = ST_TRAIL;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_TRAIL: begin
                if (ser_idle) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            done_q  <= 1'b0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        err_q  <= ERR_NONE;
                        done_q <= 1'b0;
                        left_q <= byte_count_i;
                    end
                end
                ST_PULL: begin
                    if (tmr_exp && nstatus_i) err_q <= ERR_NOSTAT;
                end
                ST_POLL: begin
                    if (!nstatus_i && tmr_exp) err_q <= ERR_TIMEOUT;
                end
                ST_FETCH: begin
                    if (abort_i) begin
                        err_q <= ERR_BOOT;
                    end else if (valid_i) begin
                        left_q <= left_q - 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (!conf_done_i) err_q <= ERR_BOOT;
                end
                ST_TRAIL: begin
                    if (ser_idle) done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign nconfig_o = (state_q != ST_PULL);
    assign ready_o   = (state_q == ST_FETCH);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign err_o     = err_q;

    // R1: idle keeps the request released and offers no stream slot
    a_r1_idle_request: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (nconfig_o && !ready_o));

    // R1: after a full idle cycle the link lines are quiet
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && $past(!busy_o)) |-> (!dclk_o && !data_o));

    // R3: the status error appears only when status was seen released
    a_r3_nostat_cause: assert property (@(posedge clk) disable iff (rst)
        (err_q == ERR_NOSTAT && $past(err_q) != ERR_NOSTAT) |-> $past(nstatus_i));

    // R4: the timeout error appears only while status was still held low
    a_r4_timeout_cause: assert property (@(posedge clk) disable iff (rst)
        (err_q == ERR_TIMEOUT && $past(err_q) != ERR_TIMEOUT) |-> !$past(nstatus_i));

    // R8: success is reported with the configuration clock parked low
    a_r8_done_clock_low: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (!dclk_o && err_o == 2'd0));

    // R10: one accepted byte closes the stream slot
    a_r10_ready_drop: assert property (@(posedge clk) disable iff (rst)
        (ready_o && valid_i && !abort_i) |=> !ready_o);

    // R11: result is held while idle and not restarted
    a_r11_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(err_o) && $stable(done_o)));

endmodule

// File: tb/pscfg_master_bench.sv
module pscfg_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P_CLK_HZ   = 10_000_000;
    localparam int P_HALF     = 2;
    localparam int P_HOLD_NS  = 2_000;
    localparam int P_TMO_NS   = 20_000;
    localparam int P_TRAIL    = 12;
    localparam int P_CNT_W    = 8;
    localparam int HOLD_CYC   = 20;   // 2000 ns at 10 MHz
    localparam int REL_DLY    = 30;   // device releases status well before timeout

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start_i = 1'b0;
    logic [P_CNT_W-1:0] byte_count_i = '0;
    logic [7:0]         data_i = '0;
    logic               valid_i = 1'b0;
    logic               ready_o;
    logic               abort_i = 1'b0;
    logic               nconfig_o;
    logic               dclk_o;
    logic               data_o;
    logic               nstatus_i = 1'b1;
    logic               conf_done_i = 1'b0;
    logic               busy_o;
    logic               done_o;
    logic [1:0]         err_o;

    pscfg_master #(
        .CLK_HZ        (P_CLK_HZ),
        .DCLK_HALF_CYC (P_HALF),
        .HOLD_NS       (P_HOLD_NS),
        .TIMEOUT_NS    (P_TMO_NS),
        .TRAIL_PULSES  (P_TRAIL),
        .CNT_W         (P_CNT_W)
    ) u_pscfg_master (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .byte_count_i (byte_count_i),
        .data_i       (data_i),
        .valid_i      (valid_i),
        .ready_o      (ready_o),
        .abort_i      (abort_i),
        .nconfig_o    (nconfig_o),
        .dclk_o       (dclk_o),
        .data_o       (data_o),
        .nstatus_i    (nstatus_i),
        .conf_done_i  (conf_done_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // stimulus / monitor state
    logic [7:0] mem [16];
    logic [7:0] cap [16];
    int  avail = 0;
    int  idx = 0;
    bit  src_en = 0;
    bit  abort_en = 0;
    bit  hs_pend = 0;
    int  hs_cnt = 0;
    int  rises = 0;
    int  nb = 0;
    int  ncfg_low = 0;
    int  viol = 0;
    int  run = 0;
    logic prev_dclk = 1'b0;
    int  dev_mode = 0;   // 0 normal, 1 status never asserted, 2 status never released
    int  rel_cnt = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lim);
        checks++;
        if (act < lim) begin
            fails++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    // host source, device model and link monitor, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (hs_pend) begin
                idx++;
                hs_cnt++;
            end
            valid_i = src_en && (idx < avail);
            data_i  = (idx < 16) ? mem[idx] : 8'h00;
            abort_i = abort_en && (idx >= avail);
            hs_pend = ready_o && valid_i && !abort_i;

            if (!nconfig_o) begin
                ncfg_low++;
                rel_cnt = 0;
                nstatus_i = (dev_mode == 1);
            end else if (dev_mode == 0) begin
                if (rel_cnt < REL_DLY) rel_cnt++;
                else nstatus_i = 1'b1;
            end else if (dev_mode == 1) begin
                nstatus_i = 1'b1;
            end

            if (dclk_o !== prev_dclk) begin
                if (busy_o && run < P_HALF) viol++;
                run = 1;
                if (dclk_o) begin
                    rises++;
                    if (rises <= 8 * nb)
                        cap[(rises - 1) / 8][(rises - 1) % 8] = data_o;
                end
            end else begin
                run++;
            end
            prev_dclk = dclk_o;
        end
    end

    task automatic setup(input int n, input int mode, input bit cdone, input int n_avail,
                         input bit do_abort);
        @(posedge clk); #1;
        nb = n; avail = n_avail; idx = 0; hs_cnt = 0; hs_pend = 0;
        rises = 0; ncfg_low = 0; viol = 0;
        dev_mode = mode; conf_done_i = cdone;
        abort_en = do_abort; src_en = 1;
        byte_count_i = P_CNT_W'(n);
        for (int i = 0; i < 16; i++) cap[i] = 8'h00;
    endtask

    task automatic run_load();
        @(posedge clk); #1;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        check("R11 start clears error", int'(err_o), 0);
        check("R11 start clears done", int'(done_o), 0);
        check("R1 busy after start", int'(busy_o), 1);
        while (busy_o) @(posedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset nconfig", int'(nconfig_o), 1);
        check("R1 reset dclk", int'(dclk_o), 0);
        check("R1 reset data", int'(data_o), 0);
        check("R1 reset ready", int'(ready_o), 0);
        check("R1 reset busy", int'(busy_o), 0);
        check("R11 reset err", int'(err_o), 0);
    endtask

    task automatic t_good(input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] b3);
        mem[0] = b0; mem[1] = b1; mem[2] = b2; mem[3] = b3;
        setup(4, 0, 1'b1, 4, 1'b0);
        run_load();
        check("R2 request low cycles", ncfg_low, HOLD_CYC);
        check_ge("R2 request low ns", ncfg_low * 100, 2000);
        for (int i = 0; i < 4; i++)
            check("R5 byte lsb first", int'(cap[i]), int'(mem[i]));
        check("R6 phase violations", viol, 0);
        check("R8 trailing rising edges", rises - 32, P_TRAIL);
        check("R8 done", int'(done_o), 1);
        check("R8 error none", int'(err_o), 0);
        check("R8 clock parked low", int'(dclk_o), 0);
        check("R10 handshakes", hs_cnt, 4);
        check("R1 ready idle", int'(ready_o), 0);
    endtask

    task automatic t_zero();
        setup(0, 0, 1'b1, 0, 1'b0);
        run_load();
        check("R12 no handshake", hs_cnt, 0);
        check("R12 only trailing edges", rises, P_TRAIL);
        check("R12 done", int'(done_o), 1);
    endtask

    task automatic t_nostat();
        mem[0] = 8'h55;
        setup(1, 1, 1'b1, 1, 1'b0);
        run_load();
        check("R3 error code", int'(err_o), 1);
        check("R3 no clock edges", rises, 0);
        check("R3 no done", int'(done_o), 0);
        check("R3 no handshake", hs_cnt, 0);
        repeat (8) @(negedge clk);
        check("R11 error held", int'(err_o), 1);
    endtask

    task automatic t_timeout();
        setup(1, 2, 1'b1, 1, 1'b0);
        run_load();
        check("R4 error code", int'(err_o), 2);
        check("R4 no clock edges", rises, 0);
        check("R1 request released", int'(nconfig_o), 1);
    endtask

    task automatic t_nodone();
        mem[0] = 8'hC3; mem[1] = 8'h18;
        setup(2, 0, 1'b0, 2, 1'b0);
        run_load();
        check("R7 error code", int'(err_o), 3);
        check("R7 no trailing edges", rises, 16);
        check("R7 bytes still sent", int'(cap[1]), 8'h18);
        check("R7 no done", int'(done_o), 0);
    endtask

    task automatic t_abort();
        mem[0] = 8'h9E; mem[1] = 8'h61; mem[2] = 8'hFF;
        setup(3, 0, 1'b1, 2, 1'b1);
        run_load();
        check("R9 error code", int'(err_o), 3);
        check("R9 edges stop at boundary", rises, 16);
        check("R9 handshakes", hs_cnt, 2);
        check("R9 clock low after abort", int'(dclk_o), 0);
        check("R9 no done", int'(done_o), 0);
        abort_en = 0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_good(8'hA5, 8'h01, 8'h80, 8'h3C);
        t_nostat();
        t_good(8'hFF, 8'h00, 8'h7E, 8'h12);
        t_timeout();
        t_nodone();
        t_abort();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule